// File: doc/BRIEF.md
# Serial EEPROM Boot Configuration Loader

This block runs once after reset. It acts as master on a two-wire serial bus and reads a small serial EEPROM from its first location to the end of its configuration area. The EEPROM contents then fill a bank of fifty-four 8-bit configuration registers. The clock line is driven directly. The data line is open-drain: the block either pulls it low or releases it. The block samples the line to read the device's acknowledge bits and data bits.

The first two bytes of the memory form a signature. Incoming configuration bytes go into a shadow buffer first. The buffer is copied into the live registers in a single cycle only if both signature bytes match. If the signature fails, or the device does not acknowledge one of the address bytes, the live registers keep their reset defaults. In every case the block ends with a sticky `done` and one of the qualifiers `loaded` or `err`, or neither.

The bus period comes from a divider of the system clock. One bit on the bus takes four phases, and each phase lasts `CLK_DIV` system cycles.

Top module: `cfg_boot_loader`

## Requirements
- R1: While reset is held and right after it, `scl_o` is 1 and `sda_oe` is 0. `done`, `loaded` and `err` are 0, and register i of `cfg_q` holds its default (3*i + 17) mod 256.
- R2: `sda_oe` never changes in the same cycle as `scl_o`. Each transfer opens with the data line falling while the clock is high (start), and the load closes with the data line rising while the clock is high (stop).
- R3: The bus sequence is fixed. First a start, then the device select byte 0xA0 (chip address 1010 with address bits 000 and write bit 0), then word address 0x00. Next a repeated start and the select byte 0xA1 (read bit 1). Last, a sequential read of REG_COUNT+2 bytes, sent most significant bit first.
- R4: After the first falling edge of the clock line, every high pulse of `scl_o` lasts exactly 2*CLK_DIV system cycles. Within a byte, every low interval also lasts 2*CLK_DIV cycles.
- R5: The master acknowledges each read byte except the last, which it answers with a NACK. A stop follows.
- R6: If byte 0 is 0x55 and byte 1 is 0x99, then after `done` rises register i equals EEPROM byte i+2, `loaded` is 1 and `err` is 0.
- R7: If byte 0 is not 0x55, or byte 1 is not 0x99, the live registers keep their defaults, and `done`=1, `loaded`=0, `err`=0.
- R8: If any of the three address bytes is not acknowledged (the data line is high in the ninth clock), the block issues a stop and reads no data byte. It then ends with `done`=1, `err`=1, `loaded`=0 and the registers at their defaults.
- R9: `done` stays 1 until reset, `cfg_q` does not change once `done` is set, and no further bus transfer starts.
- R10: `loaded` or `err` is asserted only when `done` is, and the two are never asserted together.
- R11: `cfg_q` does not change while `done` is 0. The registers are never partly loaded.
- R12: While `done` is 1, `scl_o` is 1 and `sda_oe` is 0, so the bus is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_o | output | 1 | Serial clock line level |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| sda_i | input | 1 | Sampled level of the data line |
| done | output | 1 | Sticky, set when the load sequence has ended |
| loaded | output | 1 | Signature matched and the registers were committed |
| err | output | 1 | An address byte was not acknowledged |
| cfg_q | output | REG_COUNT*8 | Live configuration registers, register i at bits [8i+7:8i] |

## Verification
A fault in the bit-phase counter or the shift register first shows on the two bus lines. It can appear as a data transition during a high clock, a high pulse of the wrong length, or a wrong select byte or word address. These show up within one bit time and are seen by a bus-level device model. A fault in the byte counter or the signature flag shows only when `done` rises, as registers shifted by one position, a commit of a bad image, or a missing final NACK. Each of the error paths and signature variants therefore runs as a separate full load, and the whole register image is compared against values computed from the injected memory contents.

// File: rtl/boot_cfg_pkg.sv
package boot_cfg_pkg;

    localparam int         CFG_REGS_DEFAULT = 54;
    localparam logic [7:0] SIG_FIRST        = 8'h55;
    localparam logic [7:0] SIG_SECOND       = 8'h99;
    // Four-bit device type code followed by three address bits tied to 000
    localparam logic [6:0] DEV_BASE         = 7'b1010_000;

    typedef enum logic [2:0] {
        OP_START,
        OP_STOP,
        OP_WRITE,
        OP_READ
    } bus_op_e;

    typedef struct packed {
        bus_op_e    op;
        logic [7:0] data;
        logic       master_ack;
    } bus_cmd_t;

    typedef struct packed {
        logic [7:0] data;
        logic       peer_ack;
    } bus_rsp_t;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_SEL_W,
        ST_WADDR,
        ST_RESTART,
        ST_SEL_R,
        ST_READ,
        ST_STOP,
        ST_FINISH,
        ST_IDLE
    } load_state_e;

    function automatic logic [7:0] reg_default(input int idx);
        return 8'((idx * 3 + 17) % 256);
    endfunction

    function automatic logic [7:0] dev_select(input logic rd);
        return {DEV_BASE, rd};
    endfunction

endpackage

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
    parameter int DIV = 625
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = !clear && (cnt == LAST);

endmodule

// File: rtl/i2c_symbol_engine.sv
module i2c_symbol_engine
    import boot_cfg_pkg::*;
#(
    parameter int DIV = 625
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_valid,
    input  bus_cmd_t cmd,
    output logic     rsp_valid,
    output bus_rsp_t rsp,
    output logic     scl_o,
    output logic     sda_oe,
    input  logic     sda_i
);
    localparam logic [3:0] ACK_SYM = 4'd8;

    logic       running;
    bus_op_e    op_q;
    logic [3:0] sym;
    logic [1:0] ph;
    logic [8:0] shf;
    logic [7:0] rxs;
    logic       ackq;
    logic       tick;
    logic       accept;
    logic       last_sym;
    logic       scl_n;
    logic       rel_n;

    assign accept = cmd_valid && !running;

    scl_phase_timer #(.DIV(DIV)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .tick  (tick)
    );

    assign last_sym = (op_q == OP_START || op_q == OP_STOP) ? (sym == 4'd0)
                                                             : (sym == ACK_SYM);

    // Line levels for the current phase of the current symbol
    always_comb begin
        scl_n = (ph == 2'd1) || (ph == 2'd2);
        rel_n = shf[8];
        unique case (op_q)
            OP_START: begin
                scl_n = (ph == 2'd1) || (ph == 2'd2);
                rel_n = !ph[1];
            end
            OP_STOP: begin
                scl_n = (ph != 2'd0);
                rel_n = ph[1];
            end
            default: begin
                scl_n = (ph == 2'd1) || (ph == 2'd2);
                rel_n = shf[8];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running   <= 1'b0;
            op_q      <= OP_START;
            sym       <= '0;
            ph        <= '0;
            shf       <= '1;
            rxs       <= '0;
            ackq      <= 1'b0;
            rsp_valid <= 1'b0;
            scl_o     <= 1'b1;
            sda_oe    <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept) begin
                running <= 1'b1;
                op_q    <= cmd.op;
                sym     <= '0;
                ph      <= '0;
                shf     <= (cmd.op == OP_READ) ? {8'hFF, !cmd.master_ack}
                                               : {cmd.data, 1'b1};
            end else if (running) begin
                scl_o  <= scl_n;
                sda_oe <= !rel_n;
                if (tick) begin
                    if (ph == 2'd2) begin
                        if (sym < ACK_SYM) begin
                            rxs <= {rxs[6:0], sda_i};
                        end else begin
                            ackq <= !sda_i;
                        end
                    end
                    if (ph == 2'd3) begin
                        if (last_sym) begin
                            running   <= 1'b0;
                            rsp_valid <= 1'b1;
                        end else begin
                            sym <= sym + 4'd1;
                            shf <= {shf[7:0], 1'b1};
                        end
                    end
                    ph <= ph + 2'd1;
                end
            end
        end
    end

    assign rsp.data     = rxs;
    assign rsp.peer_ack = ackq;

endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank
    import boot_cfg_pkg::*;
#(
    parameter int REG_COUNT = CFG_REGS_DEFAULT,
    localparam int AW = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [7:0]             wr_data,
    input  logic                   commit,
    output logic [REG_COUNT*8-1:0] live_flat
);

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        logic [7:0] shadow_q;
        logic [7:0] live_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q <= 8'h00;
                live_q   <= reg_default(g);
            end else begin
                if (wr_en && (wr_addr == AW'(g))) begin
                    shadow_q <= wr_data;
                end
                if (commit) begin
                    live_q <= shadow_q;
                end
            end
        end

        assign live_flat[g*8 +: 8] = live_q;
    end

endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
    import boot_cfg_pkg::*;
#(
    parameter int CLK_DIV   = 625,
    parameter int REG_COUNT = CFG_REGS_DEFAULT
) (
    input  logic                   clk,
    input  logic                   rst,
    output logic                   scl_o,
    output logic                   sda_oe,
    input  logic                   sda_i,
    output logic                   done,
    output logic                   loaded,
    output logic                   err,
    output logic [REG_COUNT*8-1:0] cfg_q
);
    localparam int BYTE_TOTAL = REG_COUNT + 2;
    localparam int IW = $clog2(BYTE_TOTAL + 1);
    localparam int AW = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(BYTE_TOTAL - 1);

    load_state_e    st;
    logic           pending;
    logic [IW-1:0]  idx;
    logic           sig_ok;
    logic           nack_seen;
    logic           issue;
    bus_cmd_t       cmd;
    logic           rsp_valid;
    bus_rsp_t       rsp;
    logic           wr_en;
    logic [AW-1:0]  wr_addr;
    logic           commit;

    i2c_symbol_engine #(.DIV(CLK_DIV)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (issue),
        .cmd       (cmd),
        .rsp_valid (rsp_valid),
        .rsp       (rsp),
        .scl_o     (scl_o),
        .sda_oe    (sda_oe),
        .sda_i     (sda_i)
    );

    // Command for each bus step
    always_comb begin
        cmd   = '{op: OP_START, data: 8'h00, master_ack: 1'b0};
        issue = 1'b0;
        unique case (st)
            ST_BOOT, ST_RESTART: begin
                cmd.op = OP_START;
                issue  = !pending;
            end
            ST_SEL_W: begin
                cmd.op   = OP_WRITE;
                cmd.data = dev_select(1'b0);
                issue    = !pending;
            end
            ST_WADDR: begin
                cmd.op   = OP_WRITE;
                cmd.data = 8'h00;
                issue    = !pending;
            end
            ST_SEL_R: begin
                cmd.op   = OP_WRITE;
                cmd.data = dev_select(1'b1);
                issue    = !pending;
            end
            ST_READ: begin
                cmd.op         = OP_READ;
                cmd.master_ack = (idx != LAST_IDX);
                issue          = !pending;
            end
            ST_STOP: begin
                cmd.op = OP_STOP;
                issue  = !pending;
            end
            default: begin
                issue = 1'b0;
            end
        endcase
    end

    assign wr_en   = rsp_valid && (st == ST_READ) && (idx >= IW'(2)) && sig_ok;
    assign wr_addr = AW'(idx - IW'(2));
    assign commit  = (st == ST_FINISH) && sig_ok && !nack_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_BOOT;
            pending   <= 1'b0;
            idx       <= '0;
            sig_ok    <= 1'b1;
            nack_seen <= 1'b0;
            done      <= 1'b0;
            loaded    <= 1'b0;
            err       <= 1'b0;
        end else if (st == ST_FINISH) begin
            done   <= 1'b1;
            loaded <= sig_ok && !nack_seen;
            err    <= nack_seen;
            st     <= ST_IDLE;
        end else if (rsp_valid) begin
            pending <= 1'b0;
            unique case (st)
                ST_BOOT:    st <= ST_SEL_W;
                ST_RESTART: st <= ST_SEL_R;
                ST_SEL_W, ST_WADDR, ST_SEL_R: begin
                    if (!rsp.peer_ack) begin
                        nack_seen <= 1'b1;
                        st        <= ST_STOP;
                    end else if (st == ST_SEL_W) begin
                        st <= ST_WADDR;
                    end else if (st == ST_WADDR) begin
                        st <= ST_RESTART;
                    end else begin
                        st <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (idx == IW'(0) && rsp.data != SIG_FIRST) begin
                        sig_ok <= 1'b0;
                    end
                    if (idx == IW'(1) && rsp.data != SIG_SECOND) begin
                        sig_ok <= 1'b0;
                    end
                    idx <= idx + 1'b1;
                    if (idx == LAST_IDX) begin
                        st <= ST_STOP;
                    end
                end
                ST_STOP: st <= ST_FINISH;
                default: st <= st;
            endcase
        end else if (issue) begin
            pending <= 1'b1;
        end
    end

    cfg_shadow_bank #(.REG_COUNT(REG_COUNT)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (rsp.data),
        .commit    (commit),
        .live_flat (cfg_q)
    );

endmodule

// File: rtl/cfg_boot_loader_chk.sv
module cfg_boot_loader_chk
    import boot_cfg_pkg::*;
#(
    parameter int CLK_DIV   = 625,
    parameter int REG_COUNT = CFG_REGS_DEFAULT
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   scl_o,
    input logic                   sda_oe,
    input logic                   done,
    input logic                   loaded,
    input logic                   err,
    input logic [REG_COUNT*8-1:0] cfg_q
);
    localparam int HI_LEN = 2 * CLK_DIV;

    logic [REG_COUNT*8-1:0] dflt;
    logic seen_rst;
    logic p_scl;
    logic fall_seen;
    int   hi_cnt;

    always_comb begin
        for (int i = 0; i < REG_COUNT; i++) begin
            dflt[i*8 +: 8] = reg_default(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_rst  <= 1'b1;
            p_scl     <= 1'b1;
            fall_seen <= 1'b0;
            hi_cnt    <= 0;
        end else begin
            p_scl  <= scl_o;
            hi_cnt <= scl_o ? hi_cnt + 1 : 0;
            if (p_scl && !scl_o) begin
                fall_seen <= 1'b1;
            end
        end
    end

    // R1: idle bus and default registers right after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        (seen_rst && $past(rst)) |-> (scl_o && !sda_oe && !done && !loaded && !err && cfg_q == dflt));

    // R2: data line never moves together with the clock line
    p_line_order_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(scl_o) |-> $stable(sda_oe));

    // R4: every clock high pulse after the first fall is 2*CLK_DIV cycles
    p_high_width_r4: assert property (@(posedge clk) disable iff (rst)
        (fall_seen && p_scl && !scl_o) |-> (hi_cnt == HI_LEN));

    // R9: done is sticky and the registers freeze
    p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> (done && $stable(cfg_q)));

    // R10: qualifiers only with done and never both
    p_flag_excl_r10: assert property (@(posedge clk) disable iff (rst)
        (loaded || err) |-> (done && !(loaded && err)));

    // R11: no register change before completion
    p_no_early_commit_r11: assert property (@(posedge clk) disable iff (rst)
        !done |=> ($stable(cfg_q) || done));

    // R12: bus released once finished
    p_bus_released_r12: assert property (@(posedge clk) disable iff (rst)
        done |-> (scl_o && !sda_oe));

endmodule

bind cfg_boot_loader cfg_boot_loader_chk #(
    .CLK_DIV   (CLK_DIV),
    .REG_COUNT (REG_COUNT)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .scl_o  (scl_o),
    .sda_oe (sda_oe),
    .done   (done),
    .loaded (loaded),
    .err    (err),
    .cfg_q  (cfg_q)
);

// File: tb/cfg_boot_loader_tb_top.sv
`timescale 1ns/1ps
module cfg_boot_loader_tb_top;
    localparam int DIV   = 2;
    localparam int NREG  = 54;
    localparam int NBYTE = NREG + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_o, sda_oe, done, loaded, err;
    logic [NREG*8-1:0] cfg_q;
    logic slv_low;
    logic sda_line;

    always #2 clk = ~clk;

    assign sda_line = !(sda_oe || slv_low);

    cfg_boot_loader #(.CLK_DIV(DIV), .REG_COUNT(NREG)) dut_i (
        .clk    (clk),
        .rst    (rst),
        .scl_o  (scl_o),
        .sda_oe (sda_oe),
        .sda_i  (sda_line),
        .done   (done),
        .loaded (loaded),
        .err    (err),
        .cfg_q  (cfg_q)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;

    logic [7:0] mem [256];
    int nack_sel;

    // Bus-level EEPROM model state
    int  bitk, txn, byte_no, ptr;
    bit  reading, addr_acked, rd_stop;
    logic [7:0] shreg;
    int  wr_log [4];
    int  n_wr, n_read, n_mack, n_mnack, last_nack_at, n_start, n_stop, bad_hi, hi_run;
    bit  first_fall;
    logic p_scl, p_sda;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            slv_low = 1'b0; bitk = -1; txn = 0; byte_no = 0; ptr = 0;
            reading = 0; addr_acked = 0; rd_stop = 0; shreg = 8'h00;
            n_wr = 0; n_read = 0; n_mack = 0; n_mnack = 0; last_nack_at = -1;
            n_start = 0; n_stop = 0; bad_hi = 0; hi_run = 0; first_fall = 0;
            p_scl = 1'b1; p_sda = 1'b1;
        end else begin
            if (p_scl && scl_o && p_sda && !sda_line) begin
                n_start++; txn++; bitk = -1; byte_no = 0; reading = 0; slv_low = 1'b0;
            end else if (p_scl && scl_o && !p_sda && sda_line) begin
                n_stop++; reading = 0; slv_low = 1'b0; bitk = -1;
            end else if (!p_scl && scl_o) begin
                if (bitk >= 0 && bitk < 8) begin
                    shreg = {shreg[6:0], sda_line};
                end else if (bitk == 8 && reading) begin
                    if (!sda_line) n_mack++;
                    else begin n_mnack++; last_nack_at = n_read; end
                    rd_stop = sda_line;
                    n_read++;
                end
            end else if (p_scl && !scl_o && bitk >= -1) begin
                if (bitk == 8) begin
                    if (reading) begin
                        ptr++;
                        if (rd_stop) reading = 0;
                    end else begin
                        if (n_wr < 4) wr_log[n_wr] = shreg;
                        n_wr++;
                        if (byte_no == 0 && shreg[0] && addr_acked) begin
                            reading = 1;
                        end else if (byte_no == 1) begin
                            ptr = shreg;
                        end
                        byte_no++;
                    end
                end
                bitk = (bitk == 8) ? 0 : bitk + 1;
                if (bitk == 8) begin
                    if (reading) begin
                        slv_low = 1'b0;
                    end else begin
                        addr_acked = (nack_sel != ((txn == 1) ? byte_no : 2));
                        slv_low = addr_acked;
                    end
                end else if (reading) begin
                    slv_low = !mem[ptr % 256][7 - bitk];
                end else begin
                    slv_low = 1'b0;
                end
            end
            // clock high width after the first fall
            if (p_scl && !scl_o) begin
                if (first_fall && hi_run != 2 * DIV) bad_hi++;
                first_fall = 1;
            end
            hi_run = scl_o ? hi_run + 1 : 0;
            p_scl = scl_o;
            p_sda = !(sda_oe || slv_low);
        end
    end

    function automatic int dflt(input int i);
        return (i * 3 + 17) % 256;
    endfunction

    task automatic run_case(input string name, input int seed, input int sig_mode, input int nsel);
        int mism, first_i;
        bit hung;
        logic [NREG*8-1:0] snap;
        int starts_snap;
        for (int k = 0; k < 256; k++) mem[k] = 8'((k * 29 + seed) % 256);
        mem[0] = 8'h55; mem[1] = 8'h99;
        if (sig_mode == 1) mem[0] = 8'h54;
        if (sig_mode == 2) mem[1] = 8'h98;
        if (sig_mode == 3) begin mem[0] = 8'h99; mem[1] = 8'h55; end
        nack_sel = nsel;
        $display("case %s", name);

        @(negedge clk); rst = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state
        mism = 0;
        for (int i = 0; i < NREG; i++) if (cfg_q[i*8 +: 8] != 8'(dflt(i))) mism++;
        chk(scl_o && !sda_oe && !done && !loaded && !err && mism == 0, "R1 reset state", mism, 0);
        rst = 1'b0;

        hung = 1;
        for (int t = 0; t < 30000; t++) begin
            @(negedge clk);
            if (done) begin hung = 0; break; end
        end
        chk(!hung, "R9 done reached", int'(done), 1);
        repeat (3) @(negedge clk);

        mism = 0; first_i = -1;
        for (int i = 0; i < NREG; i++) begin
            int exp_v;
            exp_v = (sig_mode == 0 && nsel < 0) ? int'(mem[i + 2]) : dflt(i);
            if (cfg_q[i*8 +: 8] != 8'(exp_v)) begin mism++; if (first_i < 0) first_i = i; end
        end

        if (nsel >= 0) begin
            chk(err && !loaded && done, "R8 err flags", {29'd0, done, loaded, err}, 5);
            chk(mism == 0, "R8 registers default", mism, 0);
            chk(n_read == 0, "R8 no data read", n_read, 0);
            chk(n_stop == 1, "R8 stop issued", n_stop, 1);
            chk(n_start == ((nsel == 2) ? 2 : 1), "R8 start count", n_start, (nsel == 2) ? 2 : 1);
        end else begin
            chk(n_start == 2 && n_stop == 1, "R2 start/stop count", n_start * 10 + n_stop, 21);
            chk(wr_log[0] == 8'hA0, "R3 select write", wr_log[0], 8'hA0);
            chk(wr_log[1] == 8'h00, "R3 word address", wr_log[1], 0);
            chk(wr_log[2] == 8'hA1, "R3 select read", wr_log[2], 8'hA1);
            chk(n_read == NBYTE, "R3 bytes read", n_read, NBYTE);
            chk(n_mack == NBYTE - 1, "R5 acks", n_mack, NBYTE - 1);
            chk(n_mnack == 1 && last_nack_at == NBYTE - 1, "R5 final nack", last_nack_at, NBYTE - 1);
            if (sig_mode == 0) begin
                chk(loaded && !err, "R6 loaded flag", int'(loaded), 1);
                chk(mism == 0, "R6 register image", first_i, -1);
            end else begin
                chk(!loaded && !err && done, "R7 flags", {30'd0, loaded, err}, 0);
                chk(mism == 0, "R7 registers default", first_i, -1);
            end
        end
        chk(bad_hi == 0, "R4 clock high width", bad_hi, 0);
        chk(loaded !== err || (!loaded && !err), "R10 exclusive flags", int'(loaded & err), 0);

        snap = cfg_q; starts_snap = n_start;
        repeat (300) @(negedge clk);
        chk(done && cfg_q == snap && n_start == starts_snap, "R9 sticky and once", n_start, starts_snap);
        chk(scl_o && !sda_oe, "R12 bus released", {30'd0, scl_o, sda_oe}, 2);
        chk(cfg_q == snap, "R11 stable image", int'(cfg_q != snap), 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                total++; bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        nack_sel = -1;
        run_case("good_a", 0, 0, -1);
        run_case("good_b", 91, 0, -1);
        run_case("good_c", 200, 0, -1);
        run_case("bad_first", 13, 1, -1);
        run_case("bad_second", 57, 2, -1);
        run_case("swapped", 5, 3, -1);
        run_case("nack_sel_w", 0, 0, 0);
        run_case("nack_waddr", 0, 0, 1);
        run_case("nack_sel_r", 0, 0, 2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule